// File: doc/BRIEF.md
# Strap-Addressed I2C Register Reader

This block is the slave side of a two-wire serial bus. It lets a host read a small file of key-status and setup bytes. Two strap inputs choose the 7-bit bus address. One of the four strap settings turns the bus function off, so the same pins can serve a different output scheme.

The host first writes one byte that sets an internal register pointer. It then issues a repeated START with the read address and clocks out as many bytes as it needs. The pointer advances after each byte sent, so a single read burst returns neighbouring registers. At the end of the file the pointer wraps back to zero. The pointer keeps its value between transactions.

The bus lines enter through two-flop synchronizers. The block samples them on a fast system clock. SDA is open-drain: the block only ever pulls it low, through `sda_oe`. Register contents come in through a combinational read port, which is indexed by the pointer.

Top module: `i2c_key_reg_slave`

## Requirements
- R1: The straps select the 7-bit address: {a1,a0}=01 gives 7, 10 gives 17 and 11 gives 117. `bus_enabled` is high for these three settings.
- R2: The block acknowledges an address byte only when its upper seven bits equal the strap address. The LSB of that byte is the R/W bit, where 1 means read. After any other address the block never pulls SDA low until the next START.
- R3: With {a1,a0}=00, `bus_enabled` is low and `sda_oe` stays low whatever happens on the bus.
- R4: The first data byte after a write address loads the pointer with its low log2(REG_COUNT) bits. Any later data bytes in the same write leave the pointer unchanged.
- R5: A read returns the register at the pointer, MSB first, with SDA changed only while SCL is low. The pointer increments after each byte is sent.
- R6: The pointer wraps from REG_COUNT-1 to 0.
- R7: When the host NACKs a read byte, the transfer ends: SDA is released and is not driven again until a new START.
- R8: The pointer keeps its value across STOP and START, so a read without a pointer write continues where the last read ended.
- R9: START is a falling SDA edge while SCL is high, and STOP is a rising SDA edge while SCL is high. A START in the middle of a byte restarts address reception. A STOP returns the block to idle with SDA released. After reset SDA is released.
- R10: Every data byte the host writes to a matched address is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_a0 | input | 1 | Address strap, low bit |
| strap_a1 | input | 1 | Address strap, high bit |
| bus_enabled | output | 1 | High when the straps select bus operation |
| rd_addr | output | PTR_W | Register file read index (current pointer) |
| rd_data | input | 8 | Register file contents at `rd_addr` |

## Verification
A wrong pointer shows up in the very next data byte the host reads. The byte carries a value computed from the wrong index, and the error repeats in every later byte of the burst. A wrong state in the bit counter or the sequencer shows up within one byte time. It appears as a missing or misplaced acknowledge, or as SDA still held low in the ninth clock after a host NACK. An error in address decoding shows up as a wrong ACK on the address byte itself, seen in every strap setting and for both matching and non-matching addresses.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } seq_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_event_t;

    typedef struct packed {
        logic              enabled;
        logic [ADDR_W-1:0] addr;
    } strap_cfg_t;

    function automatic strap_cfg_t decode_straps(input logic a1, input logic a0);
        strap_cfg_t cfg;
        cfg.enabled = a1 | a0;
        unique case ({a1, a0})
            2'b01:   cfg.addr = 7'd7;
            2'b10:   cfg.addr = 7'd17;
            2'b11:   cfg.addr = 7'd117;
            default: cfg.addr = 7'd0;
        endcase
        return cfg;
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output bus_event_t ev
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/i2cs_pointer.sv
module i2cs_pointer #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R6: one step per byte, modulo the register count
    a_r6_step_wraps: assert property (@(posedge clk) disable iff (rst)
        inc && !load |=> ptr == PTR_W'($past(ptr) + 1'b1));

    // R4: a pointer write takes effect on the next cycle
    a_r4_load_takes: assert property (@(posedge clk) disable iff (rst)
        load |=> ptr == $past(load_val));

    // R5: the sequencer never loads and steps in the same cycle
    a_r5_no_load_and_step: assert property (@(posedge clk) disable iff (rst)
        !(load && inc));

    // R8: the pointer holds when no command arrives
    a_r8_ptr_holds: assert property (@(posedge clk) disable iff (rst)
        !load && !inc |=> $stable(ptr));

endmodule

// File: rtl/i2cs_sequencer.sv
module i2cs_sequencer
    import i2cs_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_event_t        ev,
    input  strap_cfg_t        cfg,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              ptr_load,
    output logic [PTR_W-1:0]  ptr_val,
    output logic              ptr_inc
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

    seq_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              is_read;
    logic              first_wr;
    logic              host_nack;
    logic              addr_hit;

    assign addr_hit = cfg.enabled && (shreg[BYTE_W-1:1] == cfg.addr);

    always_comb begin
        ptr_load = (state == ST_WDATA) && ev.scl_fall && (cnt == LAST_RX) && first_wr;
        ptr_val  = shreg[PTR_W-1:0];
        ptr_inc  = (state == ST_RDATA) && ev.scl_fall && (cnt == LAST_TX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            is_read   <= 1'b0;
            first_wr  <= 1'b0;
            host_nack <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sda_oe <= 1'b0;
                end
                ST_ADDR, ST_WDATA: begin
                    if (ev.scl_rise && cnt < LAST_RX) begin
                        shreg <= {shreg[BYTE_W-2:0], ev.sda};
                        cnt   <= cnt + 1'b1;
                    end else if (ev.scl_fall && cnt == LAST_RX) begin
                        if (state == ST_ADDR) begin
                            if (addr_hit) begin
                                state    <= ST_AACK;
                                is_read  <= shreg[0];
                                first_wr <= 1'b1;
                                sda_oe   <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            state    <= ST_WACK;
                            first_wr <= 1'b0;
                            sda_oe   <= 1'b1;
                        end
                    end
                end
                ST_AACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (is_read) begin
                            state  <= ST_RDATA;
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end else begin
                            state  <= ST_WDATA;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_WACK: begin
                    if (ev.scl_fall) begin
                        state  <= ST_WDATA;
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (ev.scl_fall) begin
                        if (cnt == LAST_TX) begin
                            state  <= ST_RACK;
                            sda_oe <= 1'b0;
                        end else begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                            cnt    <= cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        host_nack <= ev.sda;
                    end else if (ev.scl_fall) begin
                        if (host_nack) begin
                            state  <= ST_IDLE;
                            sda_oe <= 1'b0;
                        end else begin
                            state  <= ST_RDATA;
                            cnt    <= '0;
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    // R3: a disabled strap setting never pulls the line
    a_r3_silent_when_off: assert property (@(posedge clk) disable iff (rst)
        !cfg.enabled |-> !sda_oe);

    // R5: the drive only starts while the bus clock is low
    a_r5_drive_on_low_clock: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    // R9: STOP returns to idle with SDA released
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE) && !sda_oe);

    // R7: a host NACK releases SDA at the end of the acknowledge clock
    a_r7_nack_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RACK) && ev.scl_fall && host_nack && !ev.start && !ev.stop
        |=> !sda_oe && (state == ST_IDLE));

    // R10: the bit counter never runs past one byte
    a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_RX);

    // R2: idle never pulls the line
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) && $past(state == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/i2c_key_reg_slave.sv
module i2c_key_reg_slave
    import i2cs_pkg::*;
#(
    parameter int REG_COUNT   = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PTR_W       = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              strap_a0,
    input  logic              strap_a1,
    output logic              bus_enabled,
    output logic [PTR_W-1:0]  rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);

    bus_event_t       ev;
    strap_cfg_t       cfg;
    logic             ptr_load;
    logic             ptr_inc;
    logic [PTR_W-1:0] ptr_val;

    assign cfg         = decode_straps(strap_a1, strap_a0);
    assign bus_enabled = cfg.enabled;

    i2cs_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cs_sequencer #(
        .PTR_W (PTR_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .cfg      (cfg),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val),
        .ptr_inc  (ptr_inc)
    );

    i2cs_pointer #(
        .PTR_W (PTR_W)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (ptr_val),
        .inc      (ptr_inc),
        .ptr      (rd_addr)
    );

    // R1: bus_enabled follows the strap setting
    a_r1_enable_map: assert property (@(posedge clk) disable iff (rst)
        bus_enabled == (strap_a0 || strap_a1));

endmodule

// File: tb/tb_i2c_key_reg_slave.sv
module tb_i2c_key_reg_slave;

    localparam int REGS = 16;
    localparam int PW   = 4;
    localparam int Q    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic          a0 = 1'b1;
    logic          a1 = 1'b1;
    logic          sda_oe;
    logic          bus_enabled;
    logic [PW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          sda_line;

    int n_vec = 0;
    int n_bad = 0;
    int off_drive_hits = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [7:0] reg_val(input int a);
        return 8'((a * 37 + 90) & 255);
    endfunction

    assign rd_data  = reg_val(int'(rd_addr));
    assign sda_line = m_sda & ~sda_oe;

    i2c_key_reg_slave #(.REG_COUNT(REGS)) dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .strap_a0    (a0),
        .strap_a1    (a1),
        .bus_enabled (bus_enabled),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data)
    );

    always @(negedge clk) if (!rst && !a0 && !a1 && sda_oe) off_drive_hits++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bit(input bit b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output bit b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(input bit host_ack, output logic [7:0] d);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!host_ack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        bit b;
        logic [7:0] d;
        int addrs [4] = '{7, 17, 117, 66};

        tick(5);
        rst = 1'b0;
        tick(4);
        // R9 reset releases SDA; R1 enabled with straps 11
        check(sda_oe == 1'b0, "R9 reset release", sda_oe, 0);
        check(bus_enabled == 1'b1, "R1 reset enable", bus_enabled, 1);

        // R1 R2 R3 strap and address sweep
        for (int s = 0; s < 4; s++) begin
            int exp_addr;
            a1 = s[1];
            a0 = s[0];
            off_drive_hits = 0;
            tick(4);
            exp_addr = (s == 1) ? 7 : (s == 2) ? 17 : (s == 3) ? 117 : -1;
            check(bus_enabled == (s != 0), "R1 strap enable", bus_enabled, int'(s != 0));
            for (int k = 0; k < 4; k++) begin
                bus_start();
                send_byte({7'(addrs[k]), 1'b0}, ack);
                check(ack == (addrs[k] == exp_addr), "R2 address ack", ack, int'(addrs[k] == exp_addr));
                if (addrs[k] != exp_addr) begin
                    send_byte(8'h00, ack);
                    check(ack == 1'b0, "R2 silent after miss", ack, 0);
                end
                bus_stop();
                check(sda_oe == 1'b0, "R9 stop releases", sda_oe, 0);
            end
            if (s == 0) begin
                bus_start();
                send_byte({7'd117, 1'b1}, ack);
                recv_byte(1'b0, d);
                bus_stop();
                check(off_drive_hits == 0, "R3 disabled never drives", off_drive_hits, 0);
            end
        end

        // R4 R5 R6 R7 R10 pointer sweep
        a1 = 1'b1;
        a0 = 1'b1;
        tick(4);
        for (int p = 0; p < REGS; p++) begin
            bus_start();
            send_byte({7'd117, 1'b0}, ack);
            check(ack, "R2 write address ack", ack, 1);
            send_byte(8'(p), ack);
            check(ack, "R10 data ack", ack, 1);
            bus_start();
            send_byte({7'd117, 1'b1}, ack);
            check(ack, "R2 read address ack", ack, 1);
            for (int i = 0; i < 3; i++) begin
                recv_byte(i < 2, d);
                if (p + i >= REGS)
                    check(d == reg_val((p + i) % REGS), "R6 wrap read", d, reg_val((p + i) % REGS));
                else
                    check(d == reg_val(p + i), "R5 burst read", d, reg_val(p + i));
            end
            check(sda_oe == 1'b0, "R7 nack release", sda_oe, 0);
            recv_bit(b);
            check(b == 1'b1, "R7 no drive after nack", b, 1);
            bus_stop();
        end

        // R8 pointer kept across transactions: last sweep left it at 2
        bus_start();
        send_byte({7'd117, 1'b1}, ack);
        recv_byte(1'b1, d);
        check(d == reg_val(2), "R8 continue read", d, reg_val(2));
        recv_byte(1'b0, d);
        check(d == reg_val(3), "R8 continue read", d, reg_val(3));
        bus_stop();

        // R4 later write bytes do not move the pointer
        bus_start();
        send_byte({7'd117, 1'b0}, ack);
        send_byte(8'd9, ack);
        send_byte(8'd3, ack);
        check(ack, "R10 second data ack", ack, 1);
        send_byte(8'd12, ack);
        check(ack, "R10 third data ack", ack, 1);
        bus_start();
        send_byte({7'd117, 1'b1}, ack);
        recv_byte(1'b0, d);
        check(d == reg_val(9), "R4 first byte sets pointer", d, reg_val(9));
        bus_stop();

        // R4 upper pointer bits dropped
        bus_start();
        send_byte({7'd117, 1'b0}, ack);
        send_byte(8'hF4, ack);
        bus_start();
        send_byte({7'd117, 1'b1}, ack);
        recv_byte(1'b0, d);
        check(d == reg_val(4), "R4 low bits only", d, reg_val(4));
        bus_stop();

        // R9 START inside a byte restarts address reception; pointer now 5
        bus_start();
        send_byte({7'd117, 1'b0}, ack);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        bus_start();
        send_byte({7'd117, 1'b1}, ack);
        check(ack, "R9 restart address ack", ack, 1);
        recv_byte(1'b0, d);
        check(d == reg_val(5), "R9 aborted write ignored", d, reg_val(5));
        bus_stop();
        check(sda_oe == 1'b0, "R9 idle after stop", sda_oe, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule